// File: doc/BRIEF.md
# DSP Modulo Address Generator

This block works out the next values of the X-side and Y-side data-memory address pointers for a DSP-style datapath. It also works out the address each side presents to memory. Each side receives its current pointer, an index value, a two-bit update code and a pre/post select. A shared access-size bit sets the increment and decrement step. A transfer-class flag tells a dual X/Y transfer apart from a single-data transfer.

A circular-buffer window is held in a 32-bit window register. The last address sits in the upper half and the first address in the lower half. Two enable bits place the window on the X pointer or on the Y pointer. When a dual transfer finds a windowed pointer sitting at the window end, the pointer jumps back to the window start. Only one pointer can be windowed at a time, and when both enables are set the Y side takes the window. Everything apart from the window register is combinational, so the caller writes the returned pointer values back into its own register file.

Top module: `agu_mod_top`

## Requirements
- R1: Update code 0 (hold) returns the pointer unchanged when no wrap applies.
- R2: Update code 1 (index) returns pointer plus that side's index value, modulo 2^32.
- R3: Update code 2 (increment) adds 4 when `size_long` is 1 and 2 otherwise.
- R4: Update code 3 (decrement) subtracts 4 when `size_long` is 1 and 2 otherwise.
- R5: Suppose `mod_x_en` is 1, `mod_y_en` is 0, `dual_xfer` is 1 and bits 15:0 of `x_ptr` equal the window end (bits 31:16 of the window register). Then `x_next` is bits 31:16 of `x_ptr` joined with the window start (bits 15:0 of the window register), whatever the update code.
- R6: Suppose `mod_y_en` is 1, `dual_xfer` is 1 and bits 15:0 of `y_ptr` equal the window end. Then `y_next` wraps in the same way, whatever the update code.
- R7: When both enables are 1, only the Y pointer can wrap; the X pointer follows R1 to R4.
- R8: When `dual_xfer` is 0, neither pointer wraps, whatever the enables and the window.
- R9: `x_addr`/`y_addr` equal the pre-update pointer when that side's post select is 0, and the updated value when it is 1.
- R10: The window register resets to zero and takes `mod_wdata` on a clock edge where `mod_wr` is 1; its new value governs the outputs from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_wr | input | 1 | Window register write strobe |
| mod_wdata | input | 32 | Window value: end in [31:16], start in [15:0] |
| mod_x_en | input | 1 | Place window on the X pointer |
| mod_y_en | input | 1 | Place window on the Y pointer (wins on tie) |
| dual_xfer | input | 1 | 1 = dual X/Y transfer, 0 = single-data transfer |
| size_long | input | 1 | Step of 4 when 1, step of 2 when 0 |
| x_ptr | input | 32 | Current X pointer |
| x_idx | input | 32 | X index value |
| x_op | input | 2 | X update code (0 hold, 1 index, 2 inc, 3 dec) |
| x_post | input | 1 | X access uses updated value when 1 |
| y_ptr | input | 32 | Current Y pointer |
| y_idx | input | 32 | Y index value |
| y_op | input | 2 | Y update code |
| y_post | input | 1 | Y access uses updated value when 1 |
| x_next | output | 32 | Updated X pointer |
| x_addr | output | 32 | X access address |
| y_next | output | 32 | Updated Y pointer |
| y_addr | output | 32 | Y access address |

## Verification
A wrap only happens when the low half of a pointer exactly matches the window end. That is a 1-in-65536 chance for random pointers. The stimulus therefore writes a random window first and then forces the pointer's low half onto the window end for about half of the cycles, with the upper half and the update code left random. Directed cases combine this hit with both enables set, and with a single-data transfer. This shows that the tie-break and the transfer-class gate suppress a wrap that would otherwise occur.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AGU_AW = 32;
    localparam int AGU_HW = 16;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_INDEX = 2'd1,
        UPD_INC   = 2'd2,
        UPD_DEC   = 2'd3
    } upd_e;

    typedef struct packed {
        logic [AGU_HW-1:0] stop;
        logic [AGU_HW-1:0] first;
    } win_t;

    function automatic logic [AGU_AW-1:0] lin_step(
        input logic [AGU_AW-1:0] ptr,
        input logic [AGU_AW-1:0] idx,
        input upd_e              op,
        input logic              long_sz
    );
        logic [AGU_AW-1:0] step;
        step = long_sz ? AGU_AW'(4) : AGU_AW'(2);
        case (op)
            UPD_INDEX: lin_step = ptr + idx;
            UPD_INC:   lin_step = ptr + step;
            UPD_DEC:   lin_step = ptr - step;
            default:   lin_step = ptr;
        endcase
    endfunction

endpackage

// File: rtl/agu_modreg.sv
module agu_modreg
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    output win_t        win
);
    win_t win_q;

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= '0;
        else if (wr)
            win_q <= win_t'(wdata);
    end

    assign win = win_q;

    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        wr |=> (win == win_t'($past(wdata))));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(win));

endmodule

// File: rtl/agu_lane.sv
module agu_lane
    import agu_pkg::*;
#(
    parameter int AW = AGU_AW,
    parameter int HW = AGU_HW
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] idx,
    input  upd_e          op,
    input  logic          long_sz,
    input  logic          post,
    input  logic          wrap_en,
    input  win_t          win,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] addr,
    output logic          wrapped
);
    logic [AW-1:0] lin;
    logic          at_end;

    always_comb begin
        lin     = lin_step(ptr, idx, op, long_sz);
        at_end  = (ptr[HW-1:0] == win.stop);
        wrapped = wrap_en && at_end;
        if (wrapped)
            nxt = {ptr[AW-1:HW], win.first};
        else
            nxt = lin;
        addr = post ? nxt : ptr;
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (op == UPD_HOLD && !wrapped) |-> (nxt == ptr));

    p_wrap_upper_r5: assert property (@(posedge clk) disable iff (rst)
        wrapped |-> (nxt[AW-1:HW] == ptr[AW-1:HW]));

    p_pre_addr_r9: assert property (@(posedge clk) disable iff (rst)
        !post |-> (addr == ptr));

    p_post_addr_r9: assert property (@(posedge clk) disable iff (rst)
        post |-> (addr == nxt));

endmodule

// File: rtl/agu_mod_top.sv
module agu_mod_top
    import agu_pkg::*;
#(
    parameter int AW = AGU_AW,
    parameter int HW = AGU_HW
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          mod_wr,
    input  logic [31:0]   mod_wdata,
    input  logic          mod_x_en,
    input  logic          mod_y_en,
    input  logic          dual_xfer,
    input  logic          size_long,
    input  logic [AW-1:0] x_ptr,
    input  logic [AW-1:0] x_idx,
    input  logic [1:0]    x_op,
    input  logic          x_post,
    input  logic [AW-1:0] y_ptr,
    input  logic [AW-1:0] y_idx,
    input  logic [1:0]    y_op,
    input  logic          y_post,
    output logic [AW-1:0] x_next,
    output logic [AW-1:0] x_addr,
    output logic [AW-1:0] y_next,
    output logic [AW-1:0] y_addr
);
    localparam int NSIDE = 2;

    win_t             win;
    logic [AW-1:0]    ptr_a  [NSIDE];
    logic [AW-1:0]    idx_a  [NSIDE];
    logic [1:0]       op_a   [NSIDE];
    logic             post_a [NSIDE];
    logic [AW-1:0]    nxt_a  [NSIDE];
    logic [AW-1:0]    addr_a [NSIDE];
    logic [NSIDE-1:0] wen;
    logic [NSIDE-1:0] wrapped;

    agu_modreg u_win (
        .clk   (clk),
        .rst   (rst),
        .wr    (mod_wr),
        .wdata (mod_wdata),
        .win   (win)
    );

    // Y side takes the window when both enables are set
    assign wen[1] = dual_xfer && mod_y_en;
    assign wen[0] = dual_xfer && mod_x_en && !mod_y_en;

    assign ptr_a[0]  = x_ptr;
    assign ptr_a[1]  = y_ptr;
    assign idx_a[0]  = x_idx;
    assign idx_a[1]  = y_idx;
    assign op_a[0]   = x_op;
    assign op_a[1]   = y_op;
    assign post_a[0] = x_post;
    assign post_a[1] = y_post;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        agu_lane #(.AW(AW), .HW(HW)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .ptr     (ptr_a[s]),
            .idx     (idx_a[s]),
            .op      (upd_e'(op_a[s])),
            .long_sz (size_long),
            .post    (post_a[s]),
            .wrap_en (wen[s]),
            .win     (win),
            .nxt     (nxt_a[s]),
            .addr    (addr_a[s]),
            .wrapped (wrapped[s])
        );
    end

    assign x_next = nxt_a[0];
    assign x_addr = addr_a[0];
    assign y_next = nxt_a[1];
    assign y_addr = addr_a[1];

    p_one_side_r7: assert property (@(posedge clk) disable iff (rst)
        !(wrapped[0] && wrapped[1]));

    p_tie_y_r7: assert property (@(posedge clk) disable iff (rst)
        (mod_x_en && mod_y_en) |-> !wrapped[0]);

    p_single_linear_r8: assert property (@(posedge clk) disable iff (rst)
        !dual_xfer |-> (wrapped == '0));

endmodule

// File: tb/tb_agu_mod_top.sv
module tb_agu_mod_top;

    logic        clk = 0;
    logic        rst = 1;
    logic        mod_wr = 0;
    logic [31:0] mod_wdata = 0;
    logic        mod_x_en = 0, mod_y_en = 0, dual_xfer = 0, size_long = 0;
    logic [31:0] x_ptr = 0, x_idx = 0, y_ptr = 0, y_idx = 0;
    logic [1:0]  x_op = 0, y_op = 0;
    logic        x_post = 0, y_post = 0;
    logic [31:0] x_next, x_addr, y_next, y_addr;

    int tests = 0;
    int fails = 0;
    logic [31:0] win_m = 0;
    bit done = 0;

    always #2 clk = ~clk;

    agu_mod_top dut (
        .clk(clk), .rst(rst), .mod_wr(mod_wr), .mod_wdata(mod_wdata),
        .mod_x_en(mod_x_en), .mod_y_en(mod_y_en), .dual_xfer(dual_xfer),
        .size_long(size_long), .x_ptr(x_ptr), .x_idx(x_idx), .x_op(x_op),
        .x_post(x_post), .y_ptr(y_ptr), .y_idx(y_idx), .y_op(y_op),
        .y_post(y_post), .x_next(x_next), .x_addr(x_addr),
        .y_next(y_next), .y_addr(y_addr)
    );

    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] ix,
                                             input logic [1:0] op, input logic lg,
                                             input logic wen, input logic [31:0] w);
        logic [31:0] st;
        st = lg ? 32'd4 : 32'd2;
        if (wen && p[15:0] == w[31:16]) return {p[31:16], w[15:0]};
        case (op)
            2'd1: return p + ix;
            2'd2: return p + st;
            2'd3: return p - st;
            default: return p;
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] p, input logic [1:0] op,
                                     input logic wen, input bit is_y);
        if (wen && p[15:0] == win_m[31:16]) return is_y ? "R6" : "R5";
        case (op)
            2'd1: return "R2";
            2'd2: return "R3";
            2'd3: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string extra);
        logic xw, yw;
        logic [31:0] xe, ye;
        string tx, ty;
        yw = dual_xfer && mod_y_en;
        xw = dual_xfer && mod_x_en && !mod_y_en;
        xe = ref_next(x_ptr, x_idx, x_op, size_long, xw, win_m);
        ye = ref_next(y_ptr, y_idx, y_op, size_long, yw, win_m);
        tx = (extra != "") ? extra : tag_of(x_ptr, x_op, xw, 0);
        ty = (extra != "") ? extra : tag_of(y_ptr, y_op, yw, 1);
        chk(tx, "x_next", x_next, xe);
        chk(ty, "y_next", y_next, ye);
        chk("R9", "x_addr", x_addr, x_post ? xe : x_ptr);
        chk("R9", "y_addr", y_addr, y_post ? ye : y_ptr);
    endtask

    task automatic write_win(input logic [31:0] v);
        @(negedge clk);
        mod_wr = 1; mod_wdata = v;
        @(negedge clk);
        mod_wr = 0;
        win_m = v;
    endtask

    initial begin
        #200000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: window is zero after reset, so low half 0 wraps to 0
        @(negedge clk);
        dual_xfer = 1; mod_x_en = 1; x_ptr = 32'h1234_0000; x_op = 2'd2;
        y_ptr = 32'h0000_0010; y_op = 2'd0;
        #1;
        chk("R10", "x_next reset window", x_next, 32'h1234_0000);
        check_all("");

        // R10: load window end=0x0100 start=0x0040
        write_win(32'h0100_0040);
        x_ptr = 32'hABCD_0100; x_op = 2'd3; #1;
        chk("R10", "x_next after load", x_next, 32'hABCD_0040);

        // R5 wrap on X, every update code
        for (int o = 0; o < 4; o++) begin
            x_op = o[1:0]; x_post = o[0]; #1;
            check_all("R5");
        end
        // R7: both enables -> X linear, Y wraps
        mod_y_en = 1; x_op = 2'd2; y_ptr = 32'h7777_0100; y_op = 2'd1; y_idx = 32'h55; #1;
        chk("R7", "x_next tie", x_next, 32'hABCD_0102);
        chk("R6", "y_next tie", y_next, 32'h7777_0040);
        // R8: single transfer never wraps
        dual_xfer = 0; #1;
        chk("R8", "x_next single", x_next, 32'hABCD_0102);
        chk("R8", "y_next single", y_next, 32'h7777_0155);
        // R3/R4 sizes
        size_long = 1; x_ptr = 32'hFFFF_FFFE; x_op = 2'd2; y_ptr = 32'h2; y_op = 2'd3; #1;
        chk("R3", "x_next inc4 wrap32", x_next, 32'h0000_0002);
        chk("R4", "y_next dec4 wrap32", y_next, 32'hFFFF_FFFE);

        // random phase
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) write_win($urandom);
            @(negedge clk);
            dual_xfer = ($urandom % 4) != 0;
            mod_x_en = $urandom; mod_y_en = $urandom; size_long = $urandom;
            x_ptr = $urandom; y_ptr = $urandom; x_idx = $urandom; y_idx = $urandom;
            x_op = $urandom; y_op = $urandom; x_post = $urandom; y_post = $urandom;
            if ($urandom % 2) x_ptr[15:0] = win_m[31:16];
            if ($urandom % 2) y_ptr[15:0] = win_m[31:16];
            #1;
            check_all("");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule